// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block protects an 8-bit data word with 4 check bits, forming a 12-bit code word in which the check bits sit at the power-of-two positions and the data bits fill the rest. The encoder half takes a valid-qualified data word and returns the registered code word one cycle later. The decoder half takes a valid-qualified code word and recomputes every check. It reads the resulting syndrome directly as the position of a single flipped bit, flips that bit back, and returns the corrected data with an error flag and the syndrome, also one cycle later.

Each check bit uses even parity over the positions whose index contains its power of two. Counting positions from 1, a syndrome of zero means the word is accepted as clean. A syndrome from 1 to 12 names the bad position. A syndrome of 13 to 15 cannot come from a single flip, so it is flagged as uncorrectable. Correction assumes at most one bad bit, and two flips whose positions XOR to a value of 12 or less are miscorrected. The two halves share only the clock and reset, so one instance can sit on both sides of a storage array or link.

Top module: `hamming_sec_codec`

## Requirements
- R1: Code-word bit i holds position i+1. The check bits sit at positions 1, 2, 4 and 8 (code bits 0, 1, 3, 7). Data bits 0 to 7 sit, in ascending order, at positions 3, 5, 6, 7, 9, 10, 11 and 12.
- R2: The check bit at position 2^j makes the XOR of all positions whose index has bit j set equal to zero (even parity).
- R3: The encoder output is registered. enc_valid_o equals enc_valid_i from the previous cycle, and enc_code_o is the encoding of the data word presented in that cycle.
- R4: A clean code word gives dec_syn_o = 0, dec_err_o = 0, dec_uncorr_o = 0, and dec_data_o equal to the embedded data.
- R5: A code word with one flipped data position p gives dec_syn_o = p, dec_err_o = 1, dec_uncorr_o = 0, and the original data on dec_data_o.
- R6: A code word with one flipped check position (1, 2, 4 or 8) gives dec_syn_o equal to that position, dec_err_o = 1, and dec_data_o equal to the unaltered embedded data.
- R7: A syndrome above 12 sets dec_uncorr_o = 1 and dec_err_o = 1, and dec_data_o is the data extracted from the received word with no bit flipped.
- R8: The decoder outputs are registered with one cycle of latency, and dec_valid_o equals dec_valid_i from the previous cycle.
- R9: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid_i | input | 1 | Encoder input qualifier |
| enc_data_i | input | 8 | Data word to encode |
| enc_valid_o | output | 1 | Encoder output qualifier |
| enc_code_o | output | 12 | Encoded word, bit i is position i+1 |
| dec_valid_i | input | 1 | Decoder input qualifier |
| dec_code_i | input | 12 | Received code word |
| dec_valid_o | output | 1 | Decoder output qualifier |
| dec_data_o | output | 8 | Corrected data |
| dec_err_o | output | 1 | Nonzero syndrome seen |
| dec_uncorr_o | output | 1 | Syndrome points beyond the word |
| dec_syn_o | output | 4 | Syndrome (error position) |

## Verification
The bench builds the block with its default widths, 8 data bits and 4 check bits. This size makes exhaustive coverage cheap. Every one of the 256 data words is encoded and compared with a bench-side encoding. Each word is then decoded clean and with each of the 12 single-bit flips, so every syndrome value from 0 to 12 and every correction path are reached. Random double flips chosen to push the syndrome to 13, 14 or 15 exercise the uncorrectable path, and idle cycles check that the valid outputs track their inputs.

// File: rtl/hamming_sec_codec.sv
module hamming_sec_codec #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [DATA_W+CHK_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [DATA_W+CHK_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_err_o,
  output logic              dec_uncorr_o,
  output logic [CHK_W-1:0]  dec_syn_o
);
  localparam int CODE_W = DATA_W + CHK_W;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CODE_W-1:0] place(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_pow2(p)) begin
        w[p-1] = d[k];
        k++;
      end
    end
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] extract(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = w[p-1];
        k++;
      end
    end
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(input logic [CODE_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int j = 0; j < CHK_W; j++)
      for (int p = 1; p <= CODE_W; p++)
        if (((p >> j) & 1) == 1) s[j] = s[j] ^ w[p-1];
    return s;
  endfunction

  logic [CODE_W-1:0] enc_raw, enc_word;
  logic [CHK_W-1:0]  enc_chk;

  always_comb begin
    enc_raw  = place(enc_data_i);
    enc_chk  = syndrome(enc_raw);
    enc_word = enc_raw;
    for (int j = 0; j < CHK_W; j++) enc_word[(1 << j) - 1] = enc_chk[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      enc_code_o  <= enc_word;
    end
  end

  logic [CHK_W-1:0]  syn;
  logic              beyond;
  logic [CODE_W-1:0] fixed;

  assign syn    = syndrome(dec_code_i);
  assign beyond = int'(syn) > CODE_W;

  always_comb begin
    fixed = dec_code_i;
    for (int p = 1; p <= CODE_W; p++)
      if (int'(syn) == p) fixed[p-1] = ~dec_code_i[p-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o  <= 1'b0;
      dec_data_o   <= '0;
      dec_err_o    <= 1'b0;
      dec_uncorr_o <= 1'b0;
      dec_syn_o    <= '0;
    end else begin
      dec_valid_o  <= dec_valid_i;
      dec_data_o   <= extract(fixed);
      dec_err_o    <= syn != '0;
      dec_uncorr_o <= beyond;
      dec_syn_o    <= syn;
    end
  end

  AST_ENC_VALID_HI: assert property (@(posedge clk) disable iff (!rst_n) enc_valid_i |=> enc_valid_o); // R3
  AST_ENC_VALID_LO: assert property (@(posedge clk) disable iff (!rst_n) !enc_valid_i |=> !enc_valid_o); // R3
  AST_ENC_PARITY: assert property (@(posedge clk) disable iff (!rst_n) enc_valid_o |-> syndrome(enc_code_o) == '0); // R2
  AST_ENC_DATA: assert property (@(posedge clk) disable iff (!rst_n) enc_valid_i |=> extract(enc_code_o) == $past(enc_data_i)); // R1
  AST_DEC_VALID_HI: assert property (@(posedge clk) disable iff (!rst_n) dec_valid_i |=> dec_valid_o); // R8
  AST_DEC_VALID_LO: assert property (@(posedge clk) disable iff (!rst_n) !dec_valid_i |=> !dec_valid_o); // R8
  AST_UNCORR_ERR: assert property (@(posedge clk) disable iff (!rst_n) dec_uncorr_o |-> dec_err_o); // R7
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && syndrome(dec_code_i) == '0) |=> (!dec_err_o && dec_data_o == $past(extract(dec_code_i)))); // R4
  AST_SYN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && !dec_uncorr_o) |-> int'(dec_syn_o) <= CODE_W); // R5
endmodule

// File: tb/tb_hamming_sec_codec.sv
module tb_hamming_sec_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_valid_i = 1'b0;
  logic [7:0] enc_data_i = '0;
  logic enc_valid_o;
  logic [11:0] enc_code_o;
  logic dec_valid_i = 1'b0;
  logic [11:0] dec_code_i = '0;
  logic dec_valid_o;
  logic [7:0] dec_data_o;
  logic dec_err_o, dec_uncorr_o;
  logic [3:0] dec_syn_o;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  hamming_sec_codec dut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_err_o(dec_err_o), .dec_uncorr_o(dec_uncorr_o), .dec_syn_o(dec_syn_o)
  );

  // R1: data bit k lives at this position (1-based)
  function automatic int dpos(input int k);
    case (k)
      0: return 3;  1: return 5;  2: return 6;  3: return 7;
      4: return 9;  5: return 10; 6: return 11; default: return 12;
    endcase
  endfunction

  // R1, R2: bench-side encoding
  function automatic logic [11:0] ref_encode(input logic [7:0] d);
    logic [11:0] w;
    w = '0;
    for (int k = 0; k < 8; k++) w[dpos(k)-1] = d[k];
    for (int j = 0; j < 4; j++) begin
      logic par;
      par = 1'b0;
      for (int k = 0; k < 8; k++)
        if (((dpos(k) >> j) & 1) == 1) par = par ^ d[k];
      w[(1 << j) - 1] = par;
    end
    return w;
  endfunction

  function automatic logic [7:0] ref_extract(input logic [11:0] w);
    logic [7:0] d;
    for (int k = 0; k < 8; k++) d[k] = w[dpos(k)-1];
    return d;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic encode_step(input logic [7:0] d);
    @(negedge clk);
    enc_valid_i = 1'b1;
    enc_data_i  = d;
    @(negedge clk);
    check(enc_valid_o === 1'b1, "R3 enc valid", 32'(enc_valid_o), 1);
    check(enc_code_o === ref_encode(d), "R1/R2 encode", 32'(enc_code_o), 32'(ref_encode(d)));
    enc_valid_i = 1'b0;
  endtask

  task automatic decode_step(input logic [11:0] w, input logic [3:0] syn_e, input logic err_e,
                             input logic unc_e, input logic [7:0] dat_e, input string req);
    @(negedge clk);
    dec_valid_i = 1'b1;
    dec_code_i  = w;
    @(negedge clk);
    check(dec_valid_o === 1'b1, "R8 dec valid", 32'(dec_valid_o), 1);
    check(dec_syn_o === syn_e, req, 32'(dec_syn_o), 32'(syn_e));
    check(dec_err_o === err_e, req, 32'(dec_err_o), 32'(err_e));
    check(dec_uncorr_o === unc_e, req, 32'(dec_uncorr_o), 32'(unc_e));
    check(dec_data_o === dat_e, req, 32'(dec_data_o), 32'(dat_e));
    dec_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000 * 8) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    enc_data_i = 8'hFF;
    dec_code_i = 12'hFFF;
    enc_valid_i = 1'b1;
    dec_valid_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(enc_valid_o === 1'b0 && enc_code_o === '0, "R9 enc reset", 32'(enc_code_o), 0);
    check(dec_valid_o === 1'b0 && dec_data_o === '0 && dec_err_o === 1'b0 &&
          dec_uncorr_o === 1'b0 && dec_syn_o === '0, "R9 dec reset", 32'(dec_data_o), 0);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    enc_data_i = '0;
    dec_code_i = '0;
    rst_n = 1'b1;

    // directed: position 10 flip gives syndrome 10 (R5)
    decode_step(ref_encode(8'hA5) ^ 12'(1 << 9), 4'd10, 1'b1, 1'b0, 8'hA5, "R5 pos10");

    for (int d = 0; d < 256; d++) begin
      logic [11:0] w;
      encode_step(8'(d));
      w = ref_encode(8'(d));
      decode_step(w, 4'd0, 1'b0, 1'b0, 8'(d), "R4 clean");
      for (int p = 1; p <= 12; p++) begin
        if ((p & (p - 1)) == 0)
          decode_step(w ^ 12'(1 << (p - 1)), 4'(p), 1'b1, 1'b0, 8'(d), "R6 check-bit flip");
        else
          decode_step(w ^ 12'(1 << (p - 1)), 4'(p), 1'b1, 1'b0, 8'(d), "R5 data flip");
      end
    end

    // R7: random double flips whose syndrome lands above 12
    for (int n = 0; n < 60; n++) begin
      logic [7:0] d;
      logic [11:0] w;
      int a, b;
      d = 8'($urandom);
      a = 5 + int'($urandom % 3);
      b = 8 + int'($urandom % 5);
      if ((a ^ b) > 12) begin
        w = ref_encode(d) ^ 12'(1 << (a - 1)) ^ 12'(1 << (b - 1));
        decode_step(w, 4'(a ^ b), 1'b1, 1'b1, ref_extract(w), "R7 uncorrectable");
      end
    end

    // R3, R8: idle cycle leaves valid outputs low
    @(negedge clk);
    enc_valid_i = 1'b0;
    dec_valid_i = 1'b0;
    @(negedge clk);
    check(enc_valid_o === 1'b0, "R3 enc idle", 32'(enc_valid_o), 0);
    check(dec_valid_o === 1'b0, "R8 dec idle", 32'(dec_valid_o), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule